// File: doc/BRIEF.md
# Decode-Stage Hazard and Operand Bypass Unit

This block sits beside the decode stage of a five-stage integer pipeline. Each cycle it compares the two source register numbers of the instruction in decode with the destination of the instructions now in the execute and memory stages. From that comparison it either asks the pipeline to hold decode, or it supplies a replacement value for each source operand. The value goes straight into the decode-stage operand latch rather than into the ALU input multiplexers.

A static mode input selects the policy. The first policy ignores hazards entirely. The second resolves every hazard by stalling. The third stalls only when the result is not ready yet, which happens when an execute-stage load matches a source. In every other hazard case it bypasses the result. The unit is purely combinational. Register numbers are 5 bits and data values are 32 bits by default.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A stage (execute or memory) matches a decode source only when its write enable is 1, its destination is nonzero, and the destination equals that source (`dec_rs` or `dec_rt`).
- R2: Register 0 never causes a stall or a bypass, in any mode.
- R3: With `mode` = 0 (ignore), `stall` is 0 and both select outputs are 0.
- R4: With `mode` = 1 (stall only), `stall` is 1 exactly when the execute stage or the memory stage matches either source. No bypass is made in this mode.
- R5: With `mode` = 2 (stall and bypass), `stall` is 1 exactly when the execute stage matches a source and `ex_load` is 1.
- R6: With `mode` = 2 and no stall, a source matched by the execute stage is replaced by `ex_alu`. This applies independently to rs and rt, so both are replaced when both match.
- R7: With `mode` = 2 and no stall, a source matched only by the memory stage is replaced by `mem_rdata` when `mem_load` is 1, and by `mem_alu` otherwise.
- R8: When both stages match the same source, the execute-stage value is used.
- R9: Whenever `stall` is 1, both select outputs are 0.
- R10: A bypass value output whose select is 0 reads 0. `mode` = 3 behaves exactly as `mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Hazard policy: 0 ignore, 1 stall only, 2 stall and bypass, 3 as 0 |
| dec_rs | input | 5 | First source register of the decode instruction |
| dec_rt | input | 5 | Second source register of the decode instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | 5 | Execute-stage destination register |
| ex_load | input | 1 | Execute-stage instruction reads memory |
| ex_alu | input | 32 | Execute-stage ALU result |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_load | input | 1 | Memory-stage instruction reads memory |
| mem_alu | input | 32 | Memory-stage ALU value |
| mem_rdata | input | 32 | Memory-stage load data |
| stall | output | 1 | Hold the decode stage this cycle |
| fwd_rs_sel | output | 1 | Overwrite the rs operand latch |
| fwd_rs_val | output | 32 | Replacement value for rs |
| fwd_rt_sel | output | 1 | Overwrite the rt operand latch |
| fwd_rt_val | output | 32 | Replacement value for rt |

## Verification
The assertions assume that every input is a settled, known level when they are evaluated, and that `mode` stays constant while a given input pattern is applied. The bench meets both conditions. It changes all inputs together on the falling clock edge and samples one nanosecond later. It sweeps every mode code, every source and destination value in registers 0 to 3, and every combination of write-enable and load flags. The three data inputs carry distinct patterns, so any wrong selection shows up in the checked value.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    HZ_IGNORE   = 2'd0,
    HZ_STALL    = 2'd1,
    HZ_BYPASS   = 2'd2,
    HZ_RESERVED = 2'd3
  } hz_mode_e;

  localparam int unsigned HZ_NUM_SRC = 2;
endpackage

// File: rtl/hz_stage_match.sv
module hz_stage_match #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic                  wen,
  input  logic [REG_W-1:0]      dst,
  input  logic [NSRC*REG_W-1:0] srcs,
  output logic [NSRC-1:0]       hit
);
  logic dst_live;
  assign dst_live = wen && (dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = dst_live && (dst == srcs[g*REG_W +: REG_W]);
  end
endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              bypass_ok,
  input  logic              ex_hit,
  input  logic              mem_hit,
  input  logic [DATA_W-1:0] ex_val,
  input  logic [DATA_W-1:0] mem_val,
  output logic              sel,
  output logic [DATA_W-1:0] val
);
  always_comb begin
    sel = 1'b0;
    val = '0;
    if (bypass_ok) begin
      if (ex_hit) begin
        sel = 1'b1;
        val = ex_val;
      end else if (mem_hit) begin
        sel = 1'b1;
        val = mem_val;
      end
    end
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [REG_W-1:0]  dec_rs,
  input  logic [REG_W-1:0]  dec_rt,
  input  logic              ex_wen,
  input  logic [REG_W-1:0]  ex_dst,
  input  logic              ex_load,
  input  logic [DATA_W-1:0] ex_alu,
  input  logic              mem_wen,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic              mem_load,
  input  logic [DATA_W-1:0] mem_alu,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              stall,
  output logic              fwd_rs_sel,
  output logic [DATA_W-1:0] fwd_rs_val,
  output logic              fwd_rt_sel,
  output logic [DATA_W-1:0] fwd_rt_val
);
  localparam int unsigned NSRC = HZ_NUM_SRC;

  logic [NSRC*REG_W-1:0]  srcs;
  logic [NSRC-1:0]        ex_hit, mem_hit;
  logic [NSRC-1:0]        op_sel;
  logic [DATA_W-1:0]      op_val [NSRC];
  logic [DATA_W-1:0]      mem_val;
  logic                   bypass_ok;
  hz_mode_e               md;

  assign srcs    = {dec_rt, dec_rs};
  assign md      = hz_mode_e'(mode);
  assign mem_val = mem_load ? mem_rdata : mem_alu;

  hz_stage_match #(.REG_W(REG_W), .NSRC(NSRC)) u_ex_match (
    .wen(ex_wen), .dst(ex_dst), .srcs(srcs), .hit(ex_hit)
  );

  hz_stage_match #(.REG_W(REG_W), .NSRC(NSRC)) u_mem_match (
    .wen(mem_wen), .dst(mem_dst), .srcs(srcs), .hit(mem_hit)
  );

  always_comb begin
    unique case (md)
      HZ_STALL:  stall = (|ex_hit) || (|mem_hit);
      HZ_BYPASS: stall = (|ex_hit) && ex_load;
      default:   stall = 1'b0;
    endcase
  end

  assign bypass_ok = (md == HZ_BYPASS) && !stall;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    hz_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .bypass_ok (bypass_ok),
      .ex_hit    (ex_hit[g]),
      .mem_hit   (mem_hit[g]),
      .ex_val    (ex_alu),
      .mem_val   (mem_val),
      .sel       (op_sel[g]),
      .val       (op_val[g])
    );
  end

  assign fwd_rs_sel = op_sel[0];
  assign fwd_rs_val = op_val[0];
  assign fwd_rt_sel = op_sel[1];
  assign fwd_rt_val = op_val[1];

  always_comb begin
    if (mode == 2'd0 || mode == 2'd3)
      a_r3_ignore_quiet: assert (!stall && !fwd_rs_sel && !fwd_rt_sel);
    if (stall)
      a_r9_stall_blocks_sel: assert (!fwd_rs_sel && !fwd_rt_sel);
    if (fwd_rs_sel)
      a_r2_rs_not_zero: assert (dec_rs != '0);
    if (fwd_rt_sel)
      a_r2_rt_not_zero: assert (dec_rt != '0);
    if (fwd_rs_sel && ex_wen && ex_dst == dec_rs)
      a_r8_rs_ex_first: assert (fwd_rs_val == ex_alu);
    if (mode == 2'd2 && ex_wen && ex_load && ex_dst != '0 &&
        (ex_dst == dec_rs || ex_dst == dec_rt))
      a_r5_load_stalls: assert (stall);
  end
endmodule

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  logic        clk = 1'b0;
  logic [1:0]  mode;
  logic [4:0]  dec_rs, dec_rt, ex_dst, mem_dst;
  logic        ex_wen, ex_load, mem_wen, mem_load;
  logic [31:0] ex_alu, mem_alu, mem_rdata;
  logic        stall, fwd_rs_sel, fwd_rt_sel;
  logic [31:0] fwd_rs_val, fwd_rt_val;
  int          tests = 0;
  int          fails = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  hazard_fwd_unit i_hazard_fwd_unit (
    .mode(mode), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_load(ex_load), .ex_alu(ex_alu),
    .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_load(mem_load),
    .mem_alu(mem_alu), .mem_rdata(mem_rdata),
    .stall(stall), .fwd_rs_sel(fwd_rs_sel), .fwd_rs_val(fwd_rs_val),
    .fwd_rt_sel(fwd_rt_sel), .fwd_rt_val(fwd_rt_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (mode=%0d rs=%0d rt=%0d ex=%0d/%0b/%0b mem=%0d/%0b/%0b)",
               req, act, exp, mode, dec_rs, dec_rt, ex_dst, ex_wen, ex_load,
               mem_dst, mem_wen, mem_load);
    end
  endtask

  task automatic chk_op(input logic [4:0] src, input logic exp_stall,
                        input logic sel, input logic [31:0] val);
    logic       eh, mh, es;
    logic [31:0] ev;
    string      tag;
    eh = ex_wen && ex_dst != 0 && ex_dst == src;
    mh = mem_wen && mem_dst != 0 && mem_dst == src;
    es = 1'b0; ev = 32'h0;
    if (mode == 2'd2 && !exp_stall) begin
      if (eh) begin es = 1'b1; ev = ex_alu; end
      else if (mh) begin es = 1'b1; ev = mem_load ? mem_rdata : mem_alu; end
    end
    if (mode == 2'd0 || mode == 2'd3) tag = "R3";
    else if (exp_stall)               tag = "R9";
    else if (eh && mh)                tag = "R8";
    else if (eh)                      tag = "R6";
    else if (mh)                      tag = "R7";
    else if (src == 0)                tag = "R2";
    else                              tag = "R1";
    check({tag, " select"}, {31'b0, sel}, {31'b0, es});
    check(es ? {tag, " value"} : "R10 value", val, ev);
  endtask

  initial begin
    mode = 0; dec_rs = 0; dec_rt = 0; ex_wen = 0; ex_dst = 0; ex_load = 0;
    mem_wen = 0; mem_dst = 0; mem_load = 0;
    ex_alu = 32'hE0E0_0000; mem_alu = 32'hA0A0_0000; mem_rdata = 32'hD0D0_0000;
    @(negedge clk); #1;
    check("R3 idle stall", {31'b0, stall}, 32'h0);
    check("R3 idle rs sel", {31'b0, fwd_rs_sel}, 32'h0);
    check("R3 idle rt sel", {31'b0, fwd_rt_sel}, 32'h0);
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4096; c++) begin
        logic eh_any, mh_any, exp_st;
        @(negedge clk);
        mode = m[1:0];
        {dec_rs, dec_rt, ex_dst, mem_dst} =
          {3'b0, c[1:0], 3'b0, c[3:2], 3'b0, c[5:4], 3'b0, c[7:6]};
        {ex_wen, ex_load, mem_wen, mem_load} = c[11:8];
        ex_alu    = 32'hE0E0_0000 | c;
        mem_alu   = 32'hA0A0_0000 | c;
        mem_rdata = 32'hD0D0_0000 | c;
        #1;
        eh_any = ex_wen && ex_dst != 0 && (ex_dst == dec_rs || ex_dst == dec_rt);
        mh_any = mem_wen && mem_dst != 0 && (mem_dst == dec_rs || mem_dst == dec_rt);
        case (m)
          1:       exp_st = eh_any || mh_any;
          2:       exp_st = eh_any && ex_load;
          default: exp_st = 1'b0;
        endcase
        check(m == 1 ? "R4 stall" : m == 2 ? "R5 stall" : "R10 stall",
              {31'b0, stall}, {31'b0, exp_st});
        chk_op(dec_rs, exp_st, fwd_rs_sel, fwd_rs_val);
        chk_op(dec_rt, exp_st, fwd_rt_sel, fwd_rt_val);
      end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule